// File: doc/BRIEF.md
# Quad DAC Power and Update Controller

This block is the digital control core of a four-channel digital-to-analog converter. Each 24-bit command word reaches it already shifted in. It holds an input register and an output (DAC) register for each channel, a power-down flag per channel, and the state of the internal voltage reference. It also reports whether the shared bias circuit is running, and a `ready` flag that stays low while a channel that has just woken up is still settling.

Commands take effect on the rising edge of the chip-select/load strobe `cs_ld`. The block samples that edge on the system clock. A second input, the active-low load strobe `ldac_n`, copies every input register into its output register, or wakes the outputs without loading them, depending on where `cs_ld` sits when it is used. The reference remembers which command turned it off, and that record decides what may turn it back on.

The word enters through plain strobes, not a valid/ready stream. The block accepts a command on every `cs_ld` rising edge and has no back-pressure, so the shifter in front of it never stalls.

Top module: `qdac_pwr_ctrl`

## Requirements
- R1: After reset, every input and output register is zero, no channel is powered down, the internal reference is on with `ext_ref_sel` low, `bias_on` is high and `ready` is high.
- R2: The clock edge that sees `cs_ld` go from 0 to 1 runs the word on `cmd_word`. The opcode is bits [23:20], the channel address is bits [19:16] and the data is bits [15:0]. Addresses 0 to 3 pick one channel, address 15 picks all four, and any other address picks none.
- R3: Opcode 0 writes the input register of each selected channel. Opcode 1 copies input to output for the selected channels. Opcode 2 writes the selected input registers and then updates all four outputs. Opcode 3 writes the selected channels and updates them. Every channel whose output is updated is powered up. Outputs change on no other command.
- R4: Opcode 4 powers down only the selected channels. Its data field has no effect on any register.
- R5: Opcode 5 powers down all four channels and turns off the internal reference. A reference turned off this way comes back on through opcode 6, or through any event that powers up a channel.
- R6: Opcode 7 selects the external reference and turns the internal one off. Only opcode 6 turns it back on. Updates and `ldac_n` leave it off.
- R7: Opcodes 8 to 15 change nothing.
- R8: While `cs_ld` is high, any cycle with `ldac_n` low copies all four input registers into the output registers and powers all four channels up.
- R9: A falling edge of `ldac_n` while `cs_ld` is low powers all four channels up and leaves the output registers unchanged.
- R10: If `ldac_n` is low on the `cs_ld` rising edge, the word is executed, all four outputs are then loaded from the resulting input registers, and the power-down effects of opcodes 4, 5 and 7 are dropped.
- R11: When a powered-down channel wakes, `ready` goes low for SHORT_US×CLK_MHZ cycles. If all four channels were down and the reference was off, it goes low for LONG_US×CLK_MHZ cycles instead. A new wake restarts the count.
- R12: `bias_on` is low exactly when all four channels are down and the internal reference is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_ld | input | 1 | Chip-select/load strobe, idle high; its rising edge runs a word |
| ldac_n | input | 1 | Active-low load strobe, synchronous to clk |
| cmd_word | input | 8+DW | Opcode, address and data of the word |
| dac_data | output | NCH*DW | Output registers, channel i at [i*DW +: DW] |
| pd_flags | output | NCH | Per-channel power-down flags |
| ref_en | output | 1 | Internal reference enabled |
| ext_ref_sel | output | 1 | External reference selected |
| bias_on | output | 1 | Shared bias circuit running |
| ready | output | 1 | High when no power-up settling is in progress |

## Verification
The bench sweeps every opcode across single-channel, broadcast and unmapped addresses. A decoder that treated an unmapped address as a channel, or that let opcode 4 write data, would show up as a changed output register. It then targets the reference rules. Opcode 5 followed by an update or an `ldac_n` pulse must restore the reference, while opcode 7 must survive both; a design that kept only an on/off bit for the reference fails one of these two. Power-down words sent with `ldac_n` held low must leave every channel awake, and an `ldac_n` pulse inside a low `cs_ld` window must wake the channels without loading them. The settling window is timed cycle by cycle, both after a full chip shutdown and after a single channel was down. Picking the long window from the wrong state, or from the state after the wake, gives a count off by two.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam logic [3:0] OP_WR_IN    = 4'h0;
  localparam logic [3:0] OP_UPD      = 4'h1;
  localparam logic [3:0] OP_WR_UPALL = 4'h2;
  localparam logic [3:0] OP_WR_UPD   = 4'h3;
  localparam logic [3:0] OP_PD_CH    = 4'h4;
  localparam logic [3:0] OP_PD_CHIP  = 4'h5;
  localparam logic [3:0] OP_REF_INT  = 4'h6;
  localparam logic [3:0] OP_REF_EXT  = 4'h7;
  localparam logic [3:0] ADDR_ALL    = 4'hF;

  typedef enum logic [1:0] {
    REF_ON       = 2'd0,
    REF_OFF_EXT  = 2'd1,
    REF_OFF_CHIP = 2'd2
  } ref_state_e;
endpackage

// File: rtl/qdac_cmd_decode.sv
module qdac_cmd_decode
  import qdac_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           exec,
  input  logic           suppress,
  input  logic [3:0]     op,
  input  logic [3:0]     addr,
  output logic [NCH-1:0] wr_mask,
  output logic [NCH-1:0] upd_mask,
  output logic [NCH-1:0] pd_mask,
  output logic           pd_chip,
  output logic           ref_int,
  output logic           ref_ext
);
  logic [NCH-1:0] sel;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      sel[i] = (addr == ADDR_ALL) || (addr == 4'(i));
    end
  end

  always_comb begin
    wr_mask  = '0;
    upd_mask = '0;
    pd_mask  = '0;
    pd_chip  = 1'b0;
    ref_int  = 1'b0;
    ref_ext  = 1'b0;
    if (exec) begin
      unique case (op)
        OP_WR_IN:    wr_mask = sel;
        OP_UPD:      upd_mask = sel;
        OP_WR_UPALL: begin wr_mask = sel; upd_mask = '1; end
        OP_WR_UPD:   begin wr_mask = sel; upd_mask = sel; end
        OP_PD_CH:    pd_mask = suppress ? '0 : sel;
        OP_PD_CHIP:  pd_chip = ~suppress;
        OP_REF_INT:  ref_int = 1'b1;
        OP_REF_EXT:  ref_ext = ~suppress;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          load,
  input  logic          pd_set,
  input  logic          pwr_up,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dac_q,
  output logic          pd_q,
  output logic          woke
);
  logic [DW-1:0] in_q;
  logic [DW-1:0] in_next;

  assign in_next = wr ? wdata : in_q;
  assign woke    = pd_q & pwr_up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
      pd_q  <= 1'b0;
    end else begin
      in_q <= in_next;
      if (load) dac_q <= in_next;
      if (pwr_up)      pd_q <= 1'b0;
      else if (pd_set) pd_q <= 1'b1;
    end
  end
endmodule

// File: rtl/qdac_ref_ctrl.sv
module qdac_ref_ctrl
  import qdac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_int,
  input  logic       ref_ext,
  input  logic       pd_chip,
  input  logic       any_pwr,
  output ref_state_e state_q
);
  ref_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (ref_int)                                  state_d = REF_ON;
    else if (ref_ext)                             state_d = REF_OFF_EXT;
    else if (pd_chip && state_q == REF_ON)        state_d = REF_OFF_CHIP;
    else if (any_pwr && state_q == REF_OFF_CHIP)  state_d = REF_ON;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= REF_ON;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/qdac_settle_timer.sv
module qdac_settle_timer #(
  parameter int SHORT_CYC = 600,
  parameter int LONG_CYC  = 700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_sel,
  output logic ready
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_LD = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_LD  = CW'(LONG_CYC - 1);

  logic          busy;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= long_sel ? LONG_LD : SHORT_LD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign ready = ~busy;
endmodule

// File: rtl/qdac_pwr_ctrl.sv
module qdac_pwr_ctrl
  import qdac_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 16,
  parameter int CLK_MHZ  = 50,
  parameter int SHORT_US = 12,
  parameter int LONG_US  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_ld,
  input  logic              ldac_n,
  input  logic [8+DW-1:0]   cmd_word,
  output logic [NCH*DW-1:0] dac_data,
  output logic [NCH-1:0]    pd_flags,
  output logic              ref_en,
  output logic              ext_ref_sel,
  output logic              bias_on,
  output logic              ready
);
  localparam int WW        = 8 + DW;
  localparam int SHORT_CYC = CLK_MHZ * SHORT_US;
  localparam int LONG_CYC  = CLK_MHZ * LONG_US;

  logic cs_q, ldac_q;
  logic cs_rise, ldac_fall, ldac_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      ldac_q <= 1'b1;
    end else begin
      cs_q   <= cs_ld;
      ldac_q <= ldac_n;
    end
  end

  assign cs_rise   = cs_ld & ~cs_q;
  assign ldac_fall = ~ldac_n & ldac_q;
  assign ldac_load = ~ldac_n & cs_ld;

  logic [NCH-1:0] wr_mask, upd_mask, pd_mask, pwr_up, woke;
  logic           pd_chip, ref_int, ref_ext;

  qdac_cmd_decode #(.NCH(NCH)) u_dec (
    .exec     (cs_rise),
    .suppress (~ldac_n),
    .op       (cmd_word[WW-1 -: 4]),
    .addr     (cmd_word[WW-5 -: 4]),
    .wr_mask  (wr_mask),
    .upd_mask (upd_mask),
    .pd_mask  (pd_mask),
    .pd_chip  (pd_chip),
    .ref_int  (ref_int),
    .ref_ext  (ref_ext)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      assign pwr_up[g] = upd_mask[g] | ldac_load | ldac_fall;
      qdac_channel #(.DW(DW)) u_ch (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_mask[g]),
        .load   (upd_mask[g] | ldac_load),
        .pd_set (pd_mask[g] | pd_chip),
        .pwr_up (pwr_up[g]),
        .wdata  (cmd_word[DW-1:0]),
        .dac_q  (dac_data[g*DW +: DW]),
        .pd_q   (pd_flags[g]),
        .woke   (woke[g])
      );
    end
  endgenerate

  ref_state_e ref_st;

  qdac_ref_ctrl u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_int (ref_int),
    .ref_ext (ref_ext),
    .pd_chip (pd_chip),
    .any_pwr (|pwr_up),
    .state_q (ref_st)
  );

  logic deep_off;
  assign deep_off    = (&pd_flags) & (ref_st != REF_ON);
  assign bias_on     = ~deep_off;
  assign ref_en      = (ref_st == REF_ON);
  assign ext_ref_sel = (ref_st == REF_OFF_EXT);

  qdac_settle_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (|woke),
    .long_sel (deep_off),
    .ready    (ready)
  );
endmodule

// File: rtl/qdac_pwr_ctrl_chk.sv
module qdac_pwr_ctrl_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_ld,
  input logic              ldac_n,
  input logic [8+DW-1:0]   cmd_word,
  input logic [NCH*DW-1:0] dac_data,
  input logic [NCH-1:0]    pd_flags,
  input logic              ext_ref_sel,
  input logic              ready
);
  logic cs_prev, ldac_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_prev   <= 1'b1;
      ldac_prev <= 1'b1;
    end else begin
      cs_prev   <= cs_ld;
      ldac_prev <= ldac_n;
    end
  end

  assert_ldac_wakes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_prev && !ldac_n) |=> (pd_flags == '0));

  assert_no_pd_under_ldac_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_ld && !cs_prev && !ldac_n) |=> ((pd_flags & ~$past(pd_flags)) == '0));

  assert_ext_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_ref_sel && !(cs_ld && !cs_prev && cmd_word[8+DW-1 -: 4] == 4'h6))
    |=> ext_ref_sel);

  assert_dac_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_n && !(cs_ld && !cs_prev)) |=> $stable(dac_data));

  assert_ready_after_wake_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> ($past(pd_flags) != '0));
endmodule

bind qdac_pwr_ctrl qdac_pwr_ctrl_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_ld       (cs_ld),
  .ldac_n      (ldac_n),
  .cmd_word    (cmd_word),
  .dac_data    (dac_data),
  .pd_flags    (pd_flags),
  .ext_ref_sel (ext_ref_sel),
  .ready       (ready)
);

// File: tb/qdac_pwr_ctrl_tb.sv
module qdac_pwr_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT_N = 12;
  localparam int LONG_N  = 14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_ld = 1'b1;
  logic        ldac_n = 1'b1;
  logic [23:0] cmd_word = '0;
  logic [63:0] dac_data;
  logic [3:0]  pd_flags;
  logic        ref_en, ext_ref_sel, bias_on, ready;

  int total = 0;
  int bad = 0;

  logic [15:0] ein [4];
  logic [15:0] edac [4];
  logic [3:0]  epd;
  int          eref;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdac_pwr_ctrl #(.NCH(4), .DW(16), .CLK_MHZ(1), .SHORT_US(SHORT_N), .LONG_US(LONG_N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_ld(cs_ld), .ldac_n(ldac_n), .cmd_word(cmd_word),
    .dac_data(dac_data), .pd_flags(pd_flags), .ref_en(ref_en),
    .ext_ref_sel(ext_ref_sel), .bias_on(bias_on), .ready(ready)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] op, input logic [3:0] ad, input logic [15:0] d,
                       input bit ldl, input bit fall);
    logic [3:0] sel, wr, upd, pdm, pwr;
    bit chip, ext, intr;
    sel  = (ad == 4'hF) ? 4'hF : ((ad < 4) ? (4'b0001 << ad) : 4'h0);
    wr   = (op == 0 || op == 2 || op == 3) ? sel : 4'h0;
    upd  = (op == 1 || op == 3) ? sel : ((op == 2) ? 4'hF : 4'h0);
    if (ldl) upd = 4'hF;
    pdm  = (op == 4 && !ldl) ? sel : 4'h0;
    chip = (op == 5) && !ldl;
    ext  = (op == 7) && !ldl;
    intr = (op == 6);
    pwr  = upd | (fall ? 4'hF : 4'h0);
    for (int i = 0; i < 4; i++) begin
      if (wr[i]) ein[i] = d;
      if (upd[i]) edac[i] = ein[i];
      if (pwr[i]) epd[i] = 1'b0;
      else if (pdm[i] || chip) epd[i] = 1'b1;
    end
    if (intr) eref = 0;
    else if (ext) eref = 1;
    else if (chip && eref == 0) eref = 2;
    else if (eref == 2 && pwr != 0) eref = 0;
  endtask

  task automatic chk_state(input string req);
    chk(req, dac_data, {edac[3], edac[2], edac[1], edac[0]});
    chk(req, {60'd0, pd_flags}, {60'd0, epd});
    chk(req, {62'd0, ref_en, ext_ref_sel}, {62'd0, (eref == 0), (eref == 1)});
    chk("R12", {63'd0, bias_on}, {63'd0, !(epd == 4'hF && eref != 0)});
  endtask

  // Word on the cs_ld rising edge; returns half a cycle after the edge that acts on it.
  task automatic send(input logic [3:0] op, input logic [3:0] ad, input logic [15:0] d,
                      input bit ldl);
    @(negedge clk); cs_ld = 1'b0;
    @(negedge clk); cs_ld = 1'b1; cmd_word = {op, ad, d}; ldac_n = ldl ? 1'b0 : 1'b1;
    @(negedge clk); ldac_n = 1'b1;
    model(op, ad, d, ldl, ldl);
  endtask

  task automatic ldac_level();
    @(negedge clk); ldac_n = 1'b0;
    @(negedge clk); ldac_n = 1'b1;
    model(4'hF, 4'h0, 16'h0, 1'b1, 1'b1);
  endtask

  task automatic ldac_in_window();
    @(negedge clk); cs_ld = 1'b0;
    @(negedge clk); ldac_n = 1'b0;
    @(negedge clk); ldac_n = 1'b1;
    model(4'hF, 4'h0, 16'h0, 1'b0, 1'b1);
    @(negedge clk); cs_ld = 1'b1; cmd_word = 24'hF00000;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cs_ld = 1'b1; ldac_n = 1'b1;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin ein[i] = '0; edac[i] = '0; end
    epd = '0; eref = 0;
  endtask

  task automatic settle(output int n);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    string tag;
    do_reset();
    @(negedge clk);
    chk_state("R1");
    chk("R1", {63'd0, ready}, 64'd1);

    // R2: unmapped address touches nothing, broadcast reaches all channels
    send(4'h3, 4'h5, 16'hBEEF, 1'b0); @(negedge clk); chk_state("R2");
    send(4'h3, 4'hF, 16'h1234, 1'b0); @(negedge clk); chk_state("R2");
    wait_ready();

    // sweep of every opcode over several addresses (R3..R7)
    for (int op = 0; op < 16; op++) begin
      for (int k = 0; k < 6; k++) begin
        logic [3:0] ad;
        ad = (k < 4) ? 4'(k) : ((k == 4) ? 4'h5 : 4'hF);
        send(4'(op), ad, 16'(16'h1000 * op + 16'h0111 * k + 16'h5A), 1'b0);
        @(negedge clk);
        if (op < 4) tag = "R3";
        else if (op == 4) tag = "R4";
        else if (op == 5 || op == 6) tag = "R5";
        else if (op == 7) tag = "R6";
        else tag = "R7";
        chk_state(tag);
      end
    end

    // R10: words sent with ldac low, every opcode, power-downs dropped
    for (int op = 0; op < 16; op++) begin
      send(4'(op), 4'h2, 16'(16'hC00 + op), 1'b1);
      @(negedge clk);
      chk_state("R10");
    end

    // R5 then R9: chip power-down, ldac inside a low cs window wakes without loading
    do_reset();
    send(4'h0, 4'h1, 16'hAAAA, 1'b0);
    send(4'h5, 4'h0, 16'h0, 1'b0); @(negedge clk); chk_state("R5");
    ldac_in_window(); chk_state("R9");

    // R6: external-off reference survives updates and ldac, 6 restores it
    send(4'h7, 4'h0, 16'h0, 1'b0);
    send(4'h3, 4'h2, 16'h7777, 1'b0); @(negedge clk); chk_state("R6");
    ldac_level(); @(negedge clk); chk_state("R6");
    send(4'h6, 4'h0, 16'h0, 1'b0); @(negedge clk); chk_state("R6");

    // R8: level load with cs high
    send(4'h0, 4'h3, 16'h5151, 1'b0);
    send(4'h0, 4'h0, 16'h0F0F, 1'b0);
    ldac_level(); @(negedge clk); chk_state("R8");
    wait_ready();

    // R11: long window after chip shutdown, short after one channel down
    do_reset();
    send(4'h5, 4'h0, 16'h0, 1'b0);
    send(4'h3, 4'h0, 16'h4321, 1'b0);
    settle(n); chk("R11", 64'(n), 64'(LONG_N));
    send(4'h4, 4'h1, 16'hFFFF, 1'b0);
    send(4'h3, 4'h1, 16'h2222, 1'b0);
    settle(n); chk("R11", 64'(n), 64'(SHORT_N));
    send(4'h4, 4'hF, 16'h0, 1'b0);
    send(4'h7, 4'h0, 16'h0, 1'b0);
    @(negedge clk); chk_state("R12");
    ldac_level();
    settle(n); chk("R11", 64'(n), 64'(LONG_N));
    send(4'h3, 4'h2, 16'h3333, 1'b0);
    @(negedge clk); chk("R11", {63'd0, ready}, 64'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule